// File: doc/BRIEF.md
# Controller Status Flags with Set/Clear Command Strobes

This block keeps the status flags of a serial-bus controller: the run enable, the master select, five error flags (transmit error, receive error, abort, transmit underflow, receive underflow) and a mode error flag. Software never writes a flag directly. Instead it writes a 16-bit command word in which every flag owns one set bit and one clear bit. A single write can therefore change any group of flags without a read-modify-write sequence.

Hardware error events arrive on a five-bit input. Each event raises its flag only while the matching check-enable input is high. Clearing the run enable moves the controller into configuration mode. That change is deferred while a transfer is busy, and it takes effect on the first cycle in which busy is low.

A read strobe captures a status image that also carries the live busy input. All six error flags are ORed into one error interrupt request, and an interrupt-enable input gates that request.

Top module: `ctl_status_flags`

## Requirements
- R1: After reset every flag is 0, `rd_data` is 0, `run_mode` is 0 and `err_irq` is 0.
- R2: A command write with exactly one set bit of a flag raises that flag at the next clock edge. The set bits are: bit 1 run enable, bit 3 master select, bit 5 receive underflow, bit 7 mode error, bit 12 transmit error, bit 13 receive error, bit 14 abort, bit 15 transmit underflow.
- R3: A command write with exactly one clear bit of a flag lowers that flag at the next clock edge. The clear bits are: bit 0 run enable, bit 2 master select, bit 4 receive underflow, bit 6 mode error, bit 8 transmit error, bit 9 receive error, bit 10 abort, bit 11 transmit underflow.
- R4: The command value 0x0F50 clears all six error flags in one write and leaves run enable and master select unchanged.
- R5: A cycle with `rd_stb` high loads `rd_data` with the status image and otherwise `rd_data` holds its value. The image layout is: bit 0 run enable, bit 1 master select, bit 8 transmit error, bit 9 receive error, bit 10 abort, bit 11 transmit underflow, bit 12 receive underflow, bit 13 busy, bit 14 mode error, all other bits 0.
- R6: `hw_err[i]` sets its flag at the next edge only when `chk_en[i]` is high, and has no effect otherwise. The index mapping is: 0 transmit error, 1 receive error, 2 abort, 3 transmit underflow, 4 receive underflow.
- R7: A clear of run enable while `busy` is high is held pending, and run enable stays 1. On the first edge where `busy` is low the pending clear lowers run enable. A set of run enable that arrives while the clear is pending cancels it.
- R8: When the set bit and clear bit of one flag are written together, that flag keeps its value.
- R9: A hardware error event that is enabled wins over a software clear in the same cycle, so its flag stays 1.
- R10: `err_irq` is high exactly when `irq_en` is high and at least one of the six error flags (including mode error) is 1. `run_mode` mirrors the run-enable flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Command-word write strobe |
| wr_data | input | 16 | Command word with set/clear bit pairs |
| rd_stb | input | 1 | Status read strobe |
| rd_data | output | 32 | Captured status image |
| busy | input | 1 | Transfer in progress |
| hw_err | input | 5 | Hardware error event pulses |
| chk_en | input | 5 | Per-event check enables |
| irq_en | input | 1 | Error interrupt enable |
| err_irq | output | 1 | Error interrupt request |
| run_mode | output | 1 | Run enable flag (0 = configuration mode) |

## Verification
The assertions assume the following about the inputs:
- `busy` is a level that changes only at clock edges.
- Hardware event pulses and command writes are sampled one cycle at a time, so a pending clear and a fresh set are seen as separate edge decisions.
- `rd_stb` is the only cause of a change in `rd_data`.

The stimulus meets these assumptions by driving every input on the falling clock edge and holding each strobe for exactly one cycle. The collision cases deliberately present two requests in a single cycle: set with clear, event with clear, and set with a pending clear.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int NFLAG  = 8;
  localparam int NHW    = 5;
  localparam int CMD_W  = 16;
  localparam int RD_W   = 32;
  localparam int BUSY_POS = 13;

  // flag indices
  localparam int F_EN  = 0;
  localparam int F_MS  = 1;
  localparam int F_TE  = 2;
  localparam int F_RE  = 3;
  localparam int F_AE  = 4;
  localparam int F_TUE = 5;
  localparam int F_RUE = 6;
  localparam int F_ME  = 7;

  function automatic int clr_pos(input int f);
    case (f)
      F_EN:    return 0;
      F_MS:    return 2;
      F_RUE:   return 4;
      F_ME:    return 6;
      F_TE:    return 8;
      F_RE:    return 9;
      F_AE:    return 10;
      default: return 11;
    endcase
  endfunction

  function automatic int set_pos(input int f);
    case (f)
      F_EN:    return 1;
      F_MS:    return 3;
      F_RUE:   return 5;
      F_ME:    return 7;
      F_TE:    return 12;
      F_RE:    return 13;
      F_AE:    return 14;
      default: return 15;
    endcase
  endfunction

  function automatic int rd_pos(input int f);
    case (f)
      F_EN:    return 0;
      F_MS:    return 1;
      F_TE:    return 8;
      F_RE:    return 9;
      F_AE:    return 10;
      F_TUE:   return 11;
      F_RUE:   return 12;
      default: return 14;
    endcase
  endfunction

  // hardware event source of a flag, -1 when none
  function automatic int hw_src(input int f);
    case (f)
      F_TE:    return 0;
      F_RE:    return 1;
      F_AE:    return 2;
      F_TUE:   return 3;
      F_RUE:   return 4;
      default: return -1;
    endcase
  endfunction

  function automatic bit is_err(input int f);
    return (f >= F_TE);
  endfunction

  // event beats software; set and clear together hold
  function automatic logic flag_next(input logic q, input logic set,
                                     input logic clr, input logic ev);
    if (ev)               return 1'b1;
    else if (set && !clr) return 1'b1;
    else if (clr && !set) return 1'b0;
    else                  return q;
  endfunction
endpackage

// File: rtl/sr_cmd_decode.sv
module sr_cmd_decode
  import sr_pkg::*;
#(
  parameter int N_FLAGS = NFLAG,
  parameter int W_CMD   = CMD_W
) (
  input  logic               wr_stb,
  input  logic [W_CMD-1:0]   wr_data,
  output logic [N_FLAGS-1:0] set_v,
  output logic [N_FLAGS-1:0] clr_v
);
  for (genvar f = 0; f < N_FLAGS; f++) begin : g_dec
    assign set_v[f] = wr_stb & wr_data[set_pos(f)];
    assign clr_v[f] = wr_stb & wr_data[clr_pos(f)];
  end
endmodule

// File: rtl/sr_event_gate.sv
module sr_event_gate
  import sr_pkg::*;
#(
  parameter int N_FLAGS = NFLAG,
  parameter int N_HW    = NHW
) (
  input  logic [N_HW-1:0]    hw_err,
  input  logic [N_HW-1:0]    chk_en,
  output logic [N_FLAGS-1:0] ev_hit
);
  for (genvar f = 0; f < N_FLAGS; f++) begin : g_ev
    if (hw_src(f) >= 0) begin : g_src
      assign ev_hit[f] = hw_err[hw_src(f)] & chk_en[hw_src(f)];
    end else begin : g_none
      assign ev_hit[f] = 1'b0;
    end
  end
endmodule

// File: rtl/sr_run_gate.sv
module sr_run_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ev_i,
  input  logic busy,
  output logic q,
  output logic pend_o
);
  logic set_only, clr_only, clr_go;

  assign set_only = (set_i | ev_i) & ~clr_i;
  assign clr_only = clr_i & ~set_i & ~ev_i;
  assign clr_go   = (clr_only | pend_o) & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      if (set_only)    q <= 1'b1;
      else if (clr_go) q <= 1'b0;

      if (set_only)                   pend_o <= 1'b0;
      else if (clr_only && busy && q) pend_o <= 1'b1;
      else if (!busy)                 pend_o <= 1'b0;
    end
  end

  // R7: run enable cannot drop across an edge where busy is high
  a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (q && busy) |=> q);
  // R7: a pending clear only exists while enable is set
  a_r7_pending_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |-> q);
  // R7: pending clear is applied once busy is low
  a_r7_pending_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !busy && !set_i && !ev_i) |=> !q);
endmodule

// File: rtl/sr_flag_bank.sv
module sr_flag_bank
  import sr_pkg::*;
#(
  parameter int N_FLAGS = NFLAG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] set_v,
  input  logic [N_FLAGS-1:0] clr_v,
  input  logic [N_FLAGS-1:0] ev_hit,
  input  logic               busy,
  output logic [N_FLAGS-1:0] q,
  output logic               en_pend
);
  for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
    if (f == F_EN) begin : g_run
      sr_run_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v[f]),
        .clr_i  (clr_v[f]),
        .ev_i   (ev_hit[f]),
        .busy   (busy),
        .q      (q[f]),
        .pend_o (en_pend)
      );
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[f] <= 1'b0;
        else        q[f] <= flag_next(q[f], set_v[f], clr_v[f], ev_hit[f]);
      end

      // R6 R9: an enabled event always leaves the flag set
      a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit[f] |=> q[f]);
      // R8: simultaneous set and clear keep the old value
      a_r8_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v[f] && clr_v[f] && !ev_hit[f]) |=> $stable(q[f]));
      // R3: a lone clear drops the flag
      a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v[f] && !set_v[f] && !ev_hit[f]) |=> !q[f]);
      // R2: a lone set raises the flag
      a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v[f] && !clr_v[f]) |=> q[f]);
    end
  end
endmodule

// File: rtl/sr_read_port.sv
module sr_read_port
  import sr_pkg::*;
#(
  parameter int N_FLAGS = NFLAG,
  parameter int W_RD    = RD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb,
  input  logic [N_FLAGS-1:0] flags,
  input  logic               busy,
  output logic [W_RD-1:0]    rd_data
);
  logic [W_RD-1:0] image;

  always_comb begin
    image = '0;
    for (int f = 0; f < N_FLAGS; f++) image[rd_pos(f)] = flags[f];
    image[BUSY_POS] = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= image;
  end

  // R5: read data moves only on a read strobe
  a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

// File: rtl/ctl_status_flags.sv
module ctl_status_flags
  import sr_pkg::*;
#(
  parameter int N_FLAGS = NFLAG,
  parameter int N_HW    = NHW,
  parameter int W_CMD   = CMD_W,
  parameter int W_RD    = RD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [W_CMD-1:0]  wr_data,
  input  logic              rd_stb,
  output logic [W_RD-1:0]   rd_data,
  input  logic              busy,
  input  logic [N_HW-1:0]   hw_err,
  input  logic [N_HW-1:0]   chk_en,
  input  logic              irq_en,
  output logic              err_irq,
  output logic              run_mode
);
  localparam logic [N_FLAGS-1:0] ERR_MASK = err_mask_f();

  function automatic logic [N_FLAGS-1:0] err_mask_f();
    logic [N_FLAGS-1:0] m;
    m = '0;
    for (int f = 0; f < N_FLAGS; f++) m[f] = is_err(f);
    return m;
  endfunction

  logic [N_FLAGS-1:0] set_v, clr_v, ev_hit, flags;
  logic               en_pend;
  logic               any_err;

  sr_cmd_decode #(.N_FLAGS(N_FLAGS), .W_CMD(W_CMD)) u_dec (
    .wr_stb (wr_stb),
    .wr_data(wr_data),
    .set_v  (set_v),
    .clr_v  (clr_v)
  );

  sr_event_gate #(.N_FLAGS(N_FLAGS), .N_HW(N_HW)) u_evg (
    .hw_err (hw_err),
    .chk_en (chk_en),
    .ev_hit (ev_hit)
  );

  sr_flag_bank #(.N_FLAGS(N_FLAGS)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_v  (set_v),
    .clr_v  (clr_v),
    .ev_hit (ev_hit),
    .busy   (busy),
    .q      (flags),
    .en_pend(en_pend)
  );

  sr_read_port #(.N_FLAGS(N_FLAGS), .W_RD(W_RD)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (rd_stb),
    .flags  (flags),
    .busy   (busy),
    .rd_data(rd_data)
  );

  assign any_err  = |(flags & ERR_MASK);
  assign err_irq  = irq_en & any_err;
  assign run_mode = flags[F_EN];

  // R10: mode error alone reaches the interrupt when enabled
  a_r10_mode_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && flags[F_ME]) |-> err_irq);
  // R10: no request without the enable
  a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !err_irq);
  // R4: the all-errors clear command empties the error group
  a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_data == 16'h0F50 && ev_hit == '0) |=> ((flags & ERR_MASK) == '0));
endmodule

// File: tb/sim_ctl_status_flags.sv
module sim_ctl_status_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_stb = 1'b0;
  logic [31:0] rd_data;
  logic        busy = 1'b0;
  logic [4:0]  hw_err = '0;
  logic [4:0]  chk_en = '0;
  logic        irq_en = 1'b0;
  logic        err_irq;
  logic        run_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ctl_status_flags u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_data(rd_data), .busy(busy), .hw_err(hw_err),
    .chk_en(chk_en), .irq_en(irq_en), .err_irq(err_irq), .run_mode(run_mode)
  );

  // {command word, expected status image low half}
  localparam int NV = 17;
  localparam logic [31:0] VEC [0:NV-1] = '{
    32'h0002_0001, 32'h0008_0003, 32'h1000_0103, 32'h2000_0303,
    32'h4000_0703, 32'h8000_0F03, 32'h0020_1F03, 32'h0080_5F03,
    32'h0F50_0003, 32'h00A8_5003, 32'h000C_5003, 32'h0040_1003,
    32'h0010_0003, 32'h0004_0001, 32'h0001_0000, 32'h3003_0300,
    32'h0300_0000
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [15:0] w);
    @(negedge clk); wr_stb = 1'b1; wr_data = w;
    @(negedge clk); wr_stb = 1'b0; wr_data = '0;
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0; v = rd_data;
  endtask

  task automatic pulse_ev(input logic [4:0] e);
    @(negedge clk); hw_err = e;
    @(negedge clk); hw_err = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 err_irq", {31'b0, err_irq}, 32'h0);
    check("R1 run_mode", {31'b0, run_mode}, 32'h0);
    rst_n = 1'b1;
    rd(v);
    check("R1 flags after reset", v, 32'h0);

    // table walk: R2 R3 R4 R8
    for (int i = 0; i < NV; i++) begin
      cmd(VEC[i][31:16]);
      rd(v);
      check($sformatf("R2 R3 R4 R8 step %0d", i), v, {16'h0, VEC[i][15:0]});
    end

    // R5: busy bit, hold without strobe
    cmd(16'h1000);
    @(negedge clk); busy = 1'b1;
    rd(v);
    check("R5 busy and TE", v, 32'h0000_2100);
    busy = 1'b0;
    held = v;
    cmd(16'h2000);
    repeat (2) @(negedge clk);
    check("R5 hold without strobe", rd_data, held);
    cmd(16'h0F50);

    // R6: disabled events ignored, then each event alone
    chk_en = 5'b00000;
    pulse_ev(5'b11111);
    rd(v);
    check("R6 disabled events ignored", v, 32'h0);
    for (int i = 0; i < 5; i++) begin
      chk_en = 5'b00001 << i;
      pulse_ev(5'b11111);
      rd(v);
      check($sformatf("R6 event %0d", i), v, 32'h1 << (8 + i));
      cmd(16'h0F50);
    end

    // R9: event wins over simultaneous clear
    chk_en = 5'b11111;
    @(negedge clk); hw_err = 5'b00001; wr_stb = 1'b1; wr_data = 16'h0100;
    @(negedge clk); hw_err = '0; wr_stb = 1'b0; wr_data = '0;
    rd(v);
    check("R9 event beats clear", v, 32'h0000_0100);

    // R10: interrupt gating
    irq_en = 1'b0;
    @(negedge clk);
    check("R10 gated off", {31'b0, err_irq}, 32'h0);
    irq_en = 1'b1;
    @(negedge clk);
    check("R10 TE request", {31'b0, err_irq}, 32'h1);
    cmd(16'h0F50);
    check("R10 cleared", {31'b0, err_irq}, 32'h0);
    cmd(16'h0080);
    check("R10 mode error request", {31'b0, err_irq}, 32'h1);
    cmd(16'h0040);
    check("R10 mode error cleared", {31'b0, err_irq}, 32'h0);

    // R7: deferred clear of run enable
    cmd(16'h0002);
    check("R10 run_mode set", {31'b0, run_mode}, 32'h1);
    @(negedge clk); busy = 1'b1;
    cmd(16'h0001);
    repeat (3) @(negedge clk);
    check("R7 enable held while busy", {31'b0, run_mode}, 32'h1);
    busy = 1'b0;
    @(negedge clk);
    check("R7 pending clear applied", {31'b0, run_mode}, 32'h0);
    // set cancels pending clear
    cmd(16'h0002);
    @(negedge clk); busy = 1'b1;
    cmd(16'h0001);
    cmd(16'h0002);
    @(negedge clk); busy = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 set cancels pending", {31'b0, run_mode}, 32'h1);
    // clear with busy low is immediate
    cmd(16'h0001);
    check("R3 R7 immediate clear", {31'b0, run_mode}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule